// File: doc/BRIEF.md
# Shared Steering Semaphore

This block arbitrates the use of one shared steering selector among several agents on a register bus, for example a host driver and on-chip firmware. Each agent has its own port, and the port index is the agent's identity. An agent takes the semaphore by reading it. A read that returns 1 tells the agent that it now owns the semaphore. A read that returns 0 tells it to poll again. Agents apply their own bounded wait in software, on the order of ten microseconds, and the block takes no part in that timeout.

The owner gives up the semaphore by writing a value whose bit 0 is 1. Reads have a side effect: the arbitration happens on the read strobe itself. The read result appears on the agent's read-data bus in the cycle after the strobe. In that same cycle the owner and busy outputs show the updated state. When two agents read in the same cycle, a fixed priority makes sure that only one of them can win.

Top module: `steer_sem`

## Requirements
- R1: After reset the semaphore is free: `busy_o` is 0, `owner_o` is 0 and every read-data bus is 0.
- R2: A read by agent i while the semaphore is free grants it to agent i. In the next cycle that agent's read data is 1, `busy_o` is 1 and `owner_o` is i.
- R3: A read by an agent other than the owner, while the semaphore is held, returns 0 and leaves `busy_o` and `owner_o` unchanged.
- R4: A read by the current owner returns 1 and leaves ownership unchanged.
- R5: When several agents read in the same cycle while the semaphore is free, the lowest-numbered of them is granted and is the only one whose read returns 1.
- R6: A write by the owner with bit 0 of the write data set frees the semaphore. In the next cycle `busy_o` is 0 and `owner_o` is 0.
- R7: A write by an agent that does not own the semaphore has no effect on ownership, whatever its data.
- R8: A write by the owner with bit 0 of the write data clear has no effect. The other data bits are never decoded.
- R9: A read issued in the same cycle as the release write returns 0, because the semaphore was still held at that edge. A read in any later cycle can acquire it.
- R10: Read-data bits above bit 0 are always 0, and an agent's read data is 0 in every cycle that does not follow one of its read strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_i | input | NUM_AGENTS | Read strobe, one bit per agent |
| wr_i | input | NUM_AGENTS | Write strobe, one bit per agent |
| wdata_i | input | NUM_AGENTS*DATA_W | Write data; agent i uses slice [i*DATA_W +: DATA_W] |
| rdata_o | output | NUM_AGENTS*DATA_W | Read data, valid the cycle after the strobe; agent i uses slice [i*DATA_W +: DATA_W] |
| busy_o | output | 1 | Semaphore is held |
| owner_o | output | ID_W | Index of the holding agent, 0 when free |

## Verification
The hardest cases to reach are the races on one clock edge. The first is several agents reading a free semaphore together. The second is an outside reader arriving in exactly the cycle the owner releases. The stimulus drives whole strobe vectors per cycle, so it can raise two or four read strobes at once, or pair the owner's release write with another agent's read in the same cycle. It then checks every agent's read data and the owner afterwards. The write data always carries nonzero upper bits, to show that only bit 0 is decoded.

// File: rtl/sem_pkg.sv
package sem_pkg;

    // Position of the release key inside the write data
    localparam int SEM_KEY_BIT = 0;

    // Width of an agent index, at least one bit
    function automatic int id_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sem_prio_arb.sv
module sem_prio_arb #(
    parameter int NUM_AGENTS = 4,
    parameter int ID_W       = 2
) (
    input  logic [NUM_AGENTS-1:0] req_i,
    output logic [NUM_AGENTS-1:0] gnt_o,
    output logic [ID_W-1:0]       gnt_id_o,
    output logic                  any_o
);

    logic [NUM_AGENTS:0] seen;

    assign seen[0] = 1'b0;

    // Lowest index wins: each stage is masked by all lower requests
    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_chain
        assign gnt_o[i]    = req_i[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | req_i[i];
    end

    assign any_o = seen[NUM_AGENTS];

    always_comb begin
        gnt_id_o = '0;
        for (int i = NUM_AGENTS - 1; i >= 0; i--) begin
            if (gnt_o[i]) gnt_id_o = ID_W'(i);
        end
    end

endmodule

// File: rtl/sem_owner_match.sv
module sem_owner_match #(
    parameter int NUM_AGENTS = 4,
    parameter int ID_W       = 2
) (
    input  logic                  busy_i,
    input  logic [ID_W-1:0]       owner_i,
    input  logic [NUM_AGENTS-1:0] rd_i,
    input  logic [NUM_AGENTS-1:0] wr_i,
    input  logic [NUM_AGENTS-1:0] key_i,
    output logic [NUM_AGENTS-1:0] own_rd_o,
    output logic [NUM_AGENTS-1:0] own_rel_o
);

    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_agent
        logic is_owner;
        assign is_owner     = busy_i && (owner_i == ID_W'(i));
        assign own_rd_o[i]  = rd_i[i] & is_owner;
        assign own_rel_o[i] = wr_i[i] & key_i[i] & is_owner;
    end

endmodule

// File: rtl/steer_sem.sv
module steer_sem
    import sem_pkg::*;
#(
    parameter int NUM_AGENTS = 4,
    parameter int DATA_W     = 32,
    localparam int ID_W      = id_width(NUM_AGENTS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_AGENTS-1:0]        rd_i,
    input  logic [NUM_AGENTS-1:0]        wr_i,
    input  logic [NUM_AGENTS*DATA_W-1:0] wdata_i,
    output logic [NUM_AGENTS*DATA_W-1:0] rdata_o,
    output logic                         busy_o,
    output logic [ID_W-1:0]              owner_o
);

    typedef struct packed {
        logic                  busy;
        logic [ID_W-1:0]       owner;
        logic [NUM_AGENTS-1:0] hit;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_AGENTS-1:0] key;
    logic [NUM_AGENTS-1:0] acq_req;
    logic [NUM_AGENTS-1:0] acq_gnt;
    logic [ID_W-1:0]       acq_id;
    logic                  acq_any;
    logic [NUM_AGENTS-1:0] own_rd;
    logic [NUM_AGENTS-1:0] own_rel;

    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_key
        assign key[i] = wdata_i[i*DATA_W + SEM_KEY_BIT];
    end

    // Only a free semaphore can be acquired
    assign acq_req = rd_i & {NUM_AGENTS{~state_q.busy}};

    sem_prio_arb #(
        .NUM_AGENTS(NUM_AGENTS),
        .ID_W      (ID_W)
    ) arb_i (
        .req_i   (acq_req),
        .gnt_o   (acq_gnt),
        .gnt_id_o(acq_id),
        .any_o   (acq_any)
    );

    sem_owner_match #(
        .NUM_AGENTS(NUM_AGENTS),
        .ID_W      (ID_W)
    ) match_i (
        .busy_i   (state_q.busy),
        .owner_i  (state_q.owner),
        .rd_i     (rd_i),
        .wr_i     (wr_i),
        .key_i    (key),
        .own_rd_o (own_rd),
        .own_rel_o(own_rel)
    );

    always_comb begin
        state_d     = state_q;
        state_d.hit = acq_gnt | own_rd;
        if (acq_any) begin
            state_d.busy  = 1'b1;
            state_d.owner = acq_id;
        end else if (|own_rel) begin
            state_d.busy  = 1'b0;
            state_d.owner = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_rdata
        assign rdata_o[i*DATA_W +: DATA_W] = {{(DATA_W-1){1'b0}}, state_q.hit[i]};
    end

    assign busy_o  = state_q.busy;
    assign owner_o = state_q.owner;

endmodule

// File: rtl/steer_sem_chk.sv
module steer_sem_chk #(
    parameter int NUM_AGENTS = 4,
    parameter int DATA_W     = 32,
    parameter int ID_W       = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_AGENTS-1:0]        rd_i,
    input logic [NUM_AGENTS-1:0]        wr_i,
    input logic [NUM_AGENTS*DATA_W-1:0] rdata_o,
    input logic                         busy_o,
    input logic [ID_W-1:0]              owner_o
);

    logic [NUM_AGENTS-1:0] hit_bits;
    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_bits
        assign hit_bits[i] = rdata_o[i*DATA_W];
    end

    // R5
    single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_bits));

    // R2
    take_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(|rd_i));

    // R6
    free_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(|wr_i));

    // R3
    owner_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(owner_o));

    // R6
    free_owner_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (owner_o == '0));

    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_agent
        // R4
        hit_is_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_bits[i] |-> (busy_o && owner_o == ID_W'(i)));

        // R10
        hit_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_bits[i] |-> $past(rd_i[i]));

        // R10
        upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rdata_o[i*DATA_W+1 +: DATA_W-1] == '0);
    end

endmodule

bind steer_sem steer_sem_chk #(
    .NUM_AGENTS(NUM_AGENTS),
    .DATA_W    (DATA_W),
    .ID_W      (ID_W)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .rdata_o(rdata_o),
    .busy_o (busy_o),
    .owner_o(owner_o)
);

// File: tb/steer_sem_tb_top.sv
module steer_sem_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int DW = 32;
    localparam int IW = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    rd_i;
    logic [N-1:0]    wr_i;
    logic [N*DW-1:0] wdata_i;
    logic [N*DW-1:0] rdata_o;
    logic            busy_o;
    logic [IW-1:0]   owner_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    steer_sem #(.NUM_AGENTS(N), .DATA_W(DW)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_i   (rd_i),
        .wr_i   (wr_i),
        .wdata_i(wdata_i),
        .rdata_o(rdata_o),
        .busy_o (busy_o),
        .owner_o(owner_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus cycle: strobes and per-agent key bits; upper data bits are noise
    task automatic step(input logic [N-1:0] rd, input logic [N-1:0] wr, input logic [N-1:0] key);
        @(negedge clk);
        rd_i = rd;
        wr_i = wr;
        for (int i = 0; i < N; i++) wdata_i[i*DW +: DW] = {31'h5A5A_3C3C, key[i]};
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] rdv(input int a);
        return rdata_o[a*DW +: DW];
    endfunction

    task automatic t_reset;
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 owner", 32'(owner_o), 0);
        for (int i = 0; i < N; i++) chk("R1 rdata", rdv(i), 0);
    endtask

    task automatic t_acquire;
        step(4'b0100, 4'b0000, 4'b0000);
        chk("R2 rdata agent2", rdv(2), 1);
        chk("R2 busy", 32'(busy_o), 1);
        chk("R2 owner", 32'(owner_o), 2);
        step(4'b0000, 4'b0000, 4'b0000);
        chk("R10 idle rdata agent2", rdv(2), 0);
    endtask

    task automatic t_contend;
        step(4'b0001, 4'b0000, 4'b0000);
        chk("R3 rdata agent0", rdv(0), 0);
        chk("R3 owner", 32'(owner_o), 2);
        chk("R3 busy", 32'(busy_o), 1);
        step(4'b0100, 4'b0000, 4'b0000);
        chk("R4 owner rdata", rdv(2), 1);
        chk("R4 owner", 32'(owner_o), 2);
    endtask

    task automatic t_bad_writes;
        step(4'b0000, 4'b0010, 4'b0010);
        chk("R7 busy", 32'(busy_o), 1);
        chk("R7 owner", 32'(owner_o), 2);
        step(4'b0000, 4'b0100, 4'b0000);
        chk("R8 busy", 32'(busy_o), 1);
        chk("R8 owner", 32'(owner_o), 2);
    endtask

    task automatic t_release_race;
        step(4'b1000, 4'b0100, 4'b0100);
        chk("R9 same-cycle rdata agent3", rdv(3), 0);
        chk("R6 busy", 32'(busy_o), 0);
        chk("R6 owner", 32'(owner_o), 0);
        step(4'b1000, 4'b0000, 4'b0000);
        chk("R9 later rdata agent3", rdv(3), 1);
        chk("R9 owner", 32'(owner_o), 3);
        step(4'b0000, 4'b1000, 4'b1000);
        chk("R6 busy after agent3", 32'(busy_o), 0);
    endtask

    task automatic t_simultaneous;
        step(4'b1010, 4'b0000, 4'b0000);
        chk("R5 rdata agent1", rdv(1), 1);
        chk("R5 rdata agent3", rdv(3), 0);
        chk("R5 owner", 32'(owner_o), 1);
        step(4'b0000, 4'b0010, 4'b0010);
        step(4'b1111, 4'b0000, 4'b0000);
        chk("R5 all rdata agent0", rdv(0), 1);
        for (int i = 1; i < N; i++) chk("R5 all rdata loser", rdv(i), 0);
        chk("R5 all owner", 32'(owner_o), 0);
        chk("R5 all busy", 32'(busy_o), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        rd_i    = '0;
        wr_i    = '0;
        wdata_i = '0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_acquire();
        t_contend();
        t_bad_writes();
        t_release_race();
        t_simultaneous();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule